// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

A memory-mapped watchdog that counts a 32-bit value down while it is enabled. The count advances on every clock cycle, or only on cycles where a 1 MHz tick enable is high, depending on a control bit. Software keeps the system alive by writing a fixed 16-bit key to a restart register, which reloads the counter from a reload register. Any other value written there is ignored.

When the count is already zero and another step is due, the block expires and reloads. On expiry it can send a one-cycle reset request to one of three reset scopes, send a one-cycle external event strobe, and raise a level interrupt. It also records a timeout flag. If alternate boot is armed, it also records an alternate-boot flag. While the alternate-boot flag is set, the two flash chip-select lines pass through swapped. A write to the clear register drops both flags and the interrupt, and restores the normal chip-select mapping.

The register interface is a plain write strobe with an address and data. Read data is combinational from the address.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the count and reload registers both read RELOAD_RST (default 0x0000FFFF). Control and status read 0, all event outputs are low, and `cs_n_o` equals `cs_n_i`.
- R2: Register offsets are 0x00 count (read-only), 0x04 reload (read/write), 0x08 restart (reads 0), 0x0C control (bits 7:0 writable, bits 31:8 read 0), 0x10 status and 0x14 clear (reads 0). Any other offset reads 0.
- R3: Control bit 0 enables counting. With control bit 4 at 0, the count decrements once per clock. With bit 4 at 1, it decrements only in cycles where `tick_i` is high.
- R4: Writing exactly 0x00004755 to offset 0x08 loads the count from the reload register, whether or not counting is enabled. Any other value written there leaves the count unchanged.
- R5: Clearing control bit 0 freezes the count. Setting it again resumes counting from the frozen value, without a reload.
- R6: A due step while the count is zero is an expiry. The count reloads in that same edge, and the event pulses appear high for exactly the one following cycle, so with reload value N the first pulse comes N+1 steps after counting starts.
- R7: If control bit 1 is set, an expiry pulses exactly one reset line, chosen by control bits 6:5: 00 gives `rst_soc_o`, 01 gives `rst_chip_o`, 10 gives `rst_cpu_o`, and 11 gives `rst_soc_o`. If bit 1 is clear, no reset line pulses.
- R8: If control bit 3 is set, an expiry pulses `ext_evt_o` for one cycle.
- R9: If control bit 2 is set, an expiry raises `irq_o`. It stays high until a clear write.
- R10: Every expiry sets status bit 0. An expiry with control bit 7 set also sets status bit 1. While status bit 1 is set, `cs_n_o[0]` = `cs_n_i[1]` and `cs_n_o[1]` = `cs_n_i[0]`.
- R11: Writing a value with bit 0 set to offset 0x14 clears both status bits and `irq_o`, and restores the direct chip-select mapping. A write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 MHz tick enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| cs_n_i | input | NCS | Chip selects from the flash controller |
| cs_n_o | output | NCS | Chip selects to the flash devices, pairwise swapped during alternate boot |
| irq_o | output | 1 | Expiry interrupt, held until cleared |
| rst_soc_o | output | 1 | SoC reset request pulse |
| rst_chip_o | output | 1 | Full-chip reset request pulse |
| rst_cpu_o | output | 1 | CPU-only reset request pulse |
| ext_evt_o | output | 1 | External event strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, the key 0x4755 and a reset reload of 0xFFFF. It then writes small reload values, 3 to 20, and mostly counts on every clock. This puts several expiries per scenario, and the exact cycle of each pulse, within a few dozen cycles. A separate scenario switches to tick mode and drives `tick_i` by hand, to show that idle cycles are skipped. The scenarios cover keys that differ only in the low bits and keys that carry extra upper bits. Every reset-scope code, including the spare one, is checked against the three reset lines.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] OFS_COUNT   = 8'h00;
  localparam logic [7:0] OFS_RELOAD  = 8'h04;
  localparam logic [7:0] OFS_RESTART = 8'h08;
  localparam logic [7:0] OFS_CTRL    = 8'h0C;
  localparam logic [7:0] OFS_STATUS  = 8'h10;
  localparam logic [7:0] OFS_CLEAR   = 8'h14;

  typedef enum logic [1:0] {
    SCOPE_SOC   = 2'b00,
    SCOPE_CHIP  = 2'b01,
    SCOPE_CPU   = 2'b10,
    SCOPE_SPARE = 2'b11
  } scope_e;

  // field order fixes bit positions: alt_boot=7, scope=6:5 ... en=0
  typedef struct packed {
    logic       alt_boot;
    scope_e     scope;
    logic       tick_sel;
    logic       ext_en;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY   = 16'h4755,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        status_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              restart_o,
  output logic              clear_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic sel_reload, sel_restart, sel_ctrl, sel_clear, sel_count, sel_status;

  assign sel_count   = addr_i == ADDR_W'(OFS_COUNT);
  assign sel_reload  = addr_i == ADDR_W'(OFS_RELOAD);
  assign sel_restart = addr_i == ADDR_W'(OFS_RESTART);
  assign sel_ctrl    = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_status  = addr_i == ADDR_W'(OFS_STATUS);
  assign sel_clear   = addr_i == ADDR_W'(OFS_CLEAR);

  // full-word match: upper bits must be zero
  assign restart_o = we_i && sel_restart && (wdata_i == DATA_W'(KEY));
  assign clear_o   = we_i && sel_clear && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      reload_o <= RELOAD_RST;
    end else if (we_i) begin
      if (sel_ctrl)   ctrl_o   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (sel_reload) reload_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_count)  rdata_o = DATA_W'(cnt_i);
    if (sel_reload) rdata_o = DATA_W'(reload_o);
    if (sel_ctrl)   rdata_o = DATA_W'(ctrl_o);
    if (sel_status) rdata_o = DATA_W'(status_i);
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_sel_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic step;

  assign step     = en_i && (tick_sel_i ? tick_i : 1'b1);
  assign expire_o = step && (cnt_o == '0) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= RELOAD_RST;
    else if (restart_i) cnt_o <= reload_i;
    else if (step)      cnt_o <= (cnt_o == '0) ? reload_i : cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdk_event.sv
module wdk_event
  import wdk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   expire_i,
  input  logic   clear_i,
  input  logic   alt_boot_i,
  input  scope_e scope_i,
  input  logic   rst_en_i,
  input  logic   irq_en_i,
  input  logic   ext_en_i,
  output logic   rst_soc_o,
  output logic   rst_chip_o,
  output logic   rst_cpu_o,
  output logic   ext_evt_o,
  output logic   irq_o,
  output logic [1:0] status_o
);
  logic [2:0] rst_sel;
  logic tmo_q, alt_q;

  always_comb begin
    unique case (scope_i)
      SCOPE_CHIP: rst_sel = 3'b010;
      SCOPE_CPU:  rst_sel = 3'b100;
      default:    rst_sel = 3'b001;  // SoC and spare code
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {rst_cpu_o, rst_chip_o, rst_soc_o} <= '0;
      ext_evt_o <= 1'b0;
      irq_o     <= 1'b0;
      tmo_q     <= 1'b0;
      alt_q     <= 1'b0;
    end else begin
      {rst_cpu_o, rst_chip_o, rst_soc_o} <= (expire_i && rst_en_i) ? rst_sel : 3'b000;
      ext_evt_o <= expire_i && ext_en_i;
      if (expire_i) tmo_q <= 1'b1;
      else if (clear_i) tmo_q <= 1'b0;
      if (expire_i && alt_boot_i) alt_q <= 1'b1;
      else if (clear_i) alt_q <= 1'b0;
      if (expire_i && irq_en_i) irq_o <= 1'b1;
      else if (clear_i) irq_o <= 1'b0;
    end
  end

  assign status_o = {alt_q, tmo_q};
endmodule

// File: rtl/wdk_cs_swap.sv
module wdk_cs_swap #(
  parameter int unsigned NCS = 2
) (
  input  logic           swap_i,
  input  logic [NCS-1:0] cs_n_i,
  output logic [NCS-1:0] cs_n_o
);
  for (genvar i = 0; i < NCS; i++) begin : g_pair
    localparam int unsigned PEER = i ^ 1;
    assign cs_n_o[i] = swap_i ? cs_n_i[PEER] : cs_n_i[i];
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY   = 16'h4755,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF,
  parameter int unsigned NCS        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCS-1:0]    cs_n_i,
  output logic [NCS-1:0]    cs_n_o,
  output logic              irq_o,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic              ext_evt_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             restart, clear, expire;
  logic [1:0]       status;

  wdk_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .KEY_W(KEY_W), .KEY(KEY), .RELOAD_RST(RELOAD_RST)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .status_i(status),
    .ctrl_o(ctrl_q), .reload_o(reload_q),
    .restart_o(restart), .clear_o(clear), .rdata_o
  );

  wdk_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(ctrl_q.en), .tick_sel_i(ctrl_q.tick_sel), .tick_i,
    .restart_i(restart), .reload_i(reload_q),
    .cnt_o(cnt_q), .expire_o(expire)
  );

  wdk_event u_evt (
    .clk_i, .rst_ni,
    .expire_i(expire), .clear_i(clear),
    .alt_boot_i(ctrl_q.alt_boot), .scope_i(ctrl_q.scope),
    .rst_en_i(ctrl_q.rst_en), .irq_en_i(ctrl_q.irq_en), .ext_en_i(ctrl_q.ext_en),
    .rst_soc_o, .rst_chip_o, .rst_cpu_o, .ext_evt_o, .irq_o,
    .status_o(status)
  );

  wdk_cs_swap #(.NCS(NCS)) u_cs (
    .swap_i(status[1]), .cs_n_i, .cs_n_o
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NCS    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NCS-1:0]    cs_n_i,
  input logic [NCS-1:0]    cs_n_o,
  input logic              irq_o,
  input logic              rst_soc_o,
  input logic              rst_chip_o,
  input logic              rst_cpu_o,
  input logic              ext_evt_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              en
);
  logic key_wr, clr_wr, any_evt;
  assign key_wr  = we_i && addr_i == ADDR_W'(8'h08) && wdata_i == DATA_W'(32'h4755);
  assign clr_wr  = we_i && addr_i == ADDR_W'(8'h14) && wdata_i[0];
  assign any_evt = rst_soc_o || rst_chip_o || rst_cpu_o || ext_evt_o;

  assert_key_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> cnt == $past(reload));

  assert_hold_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !key_wr) |=> $stable(cnt));

  assert_event_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |-> $past(en));

  assert_one_scope_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_soc_o, rst_chip_o, rst_cpu_o}));

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);

  assert_clear_unswaps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !en) |=> (cs_n_o == cs_n_i) && !irq_o);
endmodule

bind keyed_wdog keyed_wdog_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NCS(NCS)
) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .cs_n_i, .cs_n_o,
  .irq_o, .rst_soc_o, .rst_chip_o, .rst_cpu_o, .ext_evt_o,
  .cnt(cnt_q), .reload(reload_q), .en(ctrl_q.en)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  localparam logic [7:0] A_CNT = 8'h00, A_REL = 8'h04, A_RST = 8'h08,
                         A_CTL = 8'h0C, A_STS = 8'h10, A_CLR = 8'h14;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  cs_in = 2'b01, cs_out;
  logic        irq, r_soc, r_chip, r_cpu, ext;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyed_wdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cs_n_i(cs_in), .cs_n_o(cs_out),
    .irq_o(irq), .rst_soc_o(r_soc), .rst_chip_o(r_chip), .rst_cpu_o(r_cpu),
    .ext_evt_o(ext)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CNT, v); chk("R1 count", v, 32'hFFFF);
    rd(A_REL, v); chk("R1 reload", v, 32'hFFFF);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_STS, v); chk("R1 status", v, 0);
    chk("R1 outputs", {27'd0, irq, r_soc, r_chip, r_cpu, ext}, 0);
    chk("R1 cs", cs_out, cs_in);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_REL, 32'h1234_5678); rd(A_REL, v); chk("R2 reload rw", v, 32'h1234_5678);
    wr(A_CTL, 32'hFFFF_FF00); rd(A_CTL, v); chk("R2 ctrl upper", v, 0);
    wr(A_CTL, 32'h0000_00E6); rd(A_CTL, v); chk("R2 ctrl rw", v, 32'hE6);
    rd(A_RST, v); chk("R2 restart reads 0", v, 0);
    rd(A_CLR, v); chk("R2 clear reads 0", v, 0);
    rd(8'h1C, v); chk("R2 unmapped", v, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    wr(A_REL, 32'd40);
    wr(A_RST, 32'h0000_4754); rd(A_CNT, v); chk("R4 wrong key", v, 32'hFFFF);
    wr(A_RST, 32'h0001_4755); rd(A_CNT, v); chk("R4 key upper bits", v, 32'hFFFF);
    wr(A_RST, KEY);           rd(A_CNT, v); chk("R4 key reload while off", v, 40);
  endtask

  task automatic t_count_hold();
    logic [31:0] v;
    wr(A_REL, 32'd20); wr(A_RST, KEY);
    wr(A_CTL, 32'h1);                 // enabled after this edge
    rd(A_CNT, v); chk("R3 start", v, 20);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R3 per-clock decrement", v, 16);
    wr(A_CTL, 32'h0);                 // two more steps happen during the write
    rd(A_CNT, v); chk("R5 frozen", v, 14);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R5 still frozen", v, 14);
    wr(A_CTL, 32'h1);
    rd(A_CNT, v); chk("R5 resume no reload", v, 14);
    @(negedge clk);
    rd(A_CNT, v); chk("R5 resumed", v, 13);
    wr(A_CTL, 32'h0);
  endtask

  task automatic t_tick();
    logic [31:0] v;
    wr(A_REL, 32'd10); wr(A_RST, KEY);
    wr(A_CTL, 32'h11);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R3 tick idle", v, 10);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd(A_CNT, v); chk("R3 one tick", v, 9);
    repeat (2) @(negedge clk);
    rd(A_CNT, v); chk("R3 tick idle again", v, 9);
    wr(A_CTL, 32'h0);
  endtask

  // expects {soc,chip,cpu,ext} at the pulse cycle; reload r=3
  task automatic t_expiry(string req, logic [7:0] ctl, logic [3:0] exp);
    logic [31:0] v;
    wr(A_REL, 32'd3); wr(A_RST, KEY);
    wr(A_CTL, {24'd0, ctl | 8'h01});
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk({req, " quiet before expiry"}, {r_soc, r_chip, r_cpu, ext}, 0);
    end
    @(negedge clk);
    chk({req, " pulse"}, {r_soc, r_chip, r_cpu, ext}, exp);
    rd(A_CNT, v); chk("R6 reloaded on expiry", v, 3);
    @(negedge clk);
    chk({req, " pulse one cycle"}, {r_soc, r_chip, r_cpu, ext}, 0);
    wr(A_CTL, 0); wr(A_CLR, 1);
  endtask

  task automatic t_irq_status();
    logic [31:0] v;
    wr(A_REL, 32'd3); wr(A_RST, KEY);
    wr(A_CTL, 32'h85);                 // en, irq, alt boot
    repeat (4) @(negedge clk);
    chk("R9 irq raised", irq, 1);
    rd(A_STS, v); chk("R10 status both", v, 3);
    chk("R10 cs swapped", cs_out, 2'b10);
    cs_in = 2'b10; #1; chk("R10 cs swapped other", cs_out, 2'b01); cs_in = 2'b01;
    wr(A_CTL, 0);
    repeat (6) @(negedge clk);
    chk("R9 irq held", irq, 1);
    wr(A_CLR, 32'h0000_0002);
    rd(A_STS, v); chk("R11 clear bit0=0 ignored", v, 3);
    chk("R11 irq kept", irq, 1);
    wr(A_CLR, 32'h1);
    rd(A_STS, v); chk("R11 status cleared", v, 0);
    chk("R11 irq cleared", irq, 0);
    chk("R11 cs restored", cs_out, cs_in);
    // expiry without alt boot sets only bit 0, no swap
    wr(A_RST, KEY); wr(A_CTL, 32'h1);
    repeat (4) @(negedge clk);
    wr(A_CTL, 0);
    rd(A_STS, v); chk("R10 status timeout only", v, 1);
    chk("R10 no swap", cs_out, cs_in);
    chk("R9 irq off when disabled", irq, 0);
    wr(A_CLR, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_regmap();
    t_count_hold();
    t_tick();
    t_expiry("R7 scope00",     8'h02, 4'b1000);
    t_expiry("R7 scope01",     8'h22, 4'b0100);
    t_expiry("R7 scope10",     8'h42, 4'b0010);
    t_expiry("R7 scope11",     8'h62, 4'b1000);
    t_expiry("R7 rst disabled", 8'h60, 4'b0000);
    t_expiry("R8 ext",         8'h08, 4'b0001);
    t_expiry("R6 all events",  8'h2A, 4'b0101);
    t_irq_status();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule